// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns an asynchronous serial line back into parallel characters. A separate baud generator supplies a one-cycle enable pulse at sixteen times the bit rate, and the receiver advances only on those pulses. The data length, the parity mode and the stop length come from static control inputs, so one instance can serve any common line format without being rebuilt.

A falling edge on the idle line opens a start bit. The start bit is checked again halfway through, and the receiver drops back to idle if the line has already returned high. Each later bit is sampled at its centre, least significant data bit first. Every completed character is loaded into a holding register with a data-ready flag and four error flags: parity, framing, break and overrun. A read strobe from the host clears data-ready and the flags. All state changes on the rising clock edge. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `uart_rx_core`

## Requirements
- R1: `len_sel` sets the number of data bits to 5 + `len_sel` (00 = 5, 01 = 6, 10 = 7, 11 = 8). Data bits arrive least significant first, and `rx_data` bits above the programmed length read 0.
- R2: `par_mode` 01 selects even parity and 10 selects odd parity. 00 and 11 both mean no parity bit. With parity on, a received parity bit that does not match the data sets `err_parity`. With parity off, `err_parity` stays 0.
- R3: `stop_sel` 00 selects one stop bit, 01 one and a half, and 10 or 11 two. After the first stop bit is sampled, the receiver ignores the line for the rest of the programmed stop time, so a falling edge inside that time starts no character.
- R4: A start bit is accepted only if the line is still low on the 8th tick after the falling edge was seen. Otherwise the receiver returns to idle, produces no character, and still receives the next valid character correctly.
- R5: Each bit after the start bit is sampled 16 ticks after the previous one. No receive state changes on cycles without `tick16`, so with no ticks nothing is received.
- R6: `err_frame` is set when the first stop bit is sampled low. Any further stop bits are not checked.
- R7: `err_break` is set, together with `err_frame` and with `rx_data` = 0, when the start, data, parity and first stop samples are all low. While the line stays low afterwards, no new character begins.
- R8: If a character completes while `data_ready` is still set, `err_overrun` is set and the new character replaces the old one in `rx_data`.
- R9: Every completed character is loaded into `rx_data` with `data_ready` = 1 and with its parity, framing and break flags.
- R10: `rd_strobe` clears `data_ready` and all four error flags. A character that completes in the same cycle as the strobe still leaves `data_ready` set.
- R11: After reset, `data_ready`, all error flags and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Serial line, idles high |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| len_sel | input | 2 | Data length select |
| par_mode | input | 2 | Parity mode select |
| stop_sel | input | 2 | Stop length select |
| rd_strobe | input | 1 | Host read, clears data-ready and flags |
| rx_data | output | 8 | Holding register contents |
| data_ready | output | 1 | A character is waiting |
| err_overrun | output | 1 | A character was lost to overrun |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | First stop bit sampled low |
| err_break | output | 1 | Whole character time was low |

## Verification
The checks assume that `tick16` is a single-cycle pulse and that the format inputs do not change while a character is in flight. The no-parity check in particular reads `par_mode` at completion as if it were the mode used for the whole frame. The bench sets the format only while the line is idle, between characters. It generates the tick every second clock and holds each bit for exactly sixteen ticks, so the centre samples land well clear of any edge. The error cases are driven deliberately as malformed waveforms: a flipped parity bit, a low stop bit, a held-low line and a short glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DATA_W  = 8;
  localparam int RX_MIN_LEN = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_TAIL  = 3'd5
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE     = 2'b00,
    PAR_EVEN     = 2'b01,
    PAR_ODD      = 2'b10,
    PAR_NONE_ALT = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    STOP_ONE     = 2'b00,
    STOP_ONEHALF = 2'b01,
    STOP_TWO     = 2'b10,
    STOP_TWO_ALT = 2'b11
  } stop_mode_e;

  typedef struct packed {
    logic [RX_DATA_W-1:0] data;
    logic                 perr;
    logic                 ferr;
    logic                 brk;
  } char_rec_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_s,
  input  logic      tick_en,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_sel,
  input  logic [1:0] stop_sel,
  output logic      char_done,
  output char_rec_t char_rec
);

  localparam int CNT_W  = $clog2(OS_RATE);
  localparam int BIDX_W = $clog2(RX_DATA_W);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);

  rx_state_e            state_q, state_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [BIDX_W-1:0]    idx_q, idx_n;
  logic [RX_DATA_W-1:0] shreg_q, shreg_n;
  logic                 par_q, par_n;
  logic                 low_q, low_n;
  logic                 perr_q, perr_n;
  logic                 prev_q, prev_n;
  logic                 done_q, done_n;
  char_rec_t            rec_q, rec_n;

  logic              par_en;
  logic              par_odd;
  logic [BIDX_W-1:0] last_idx;
  logic [CNT_W-1:0]  tail_last;

  assign par_en    = (par_sel == PAR_EVEN) || (par_sel == PAR_ODD);
  assign par_odd   = (par_sel == PAR_ODD);
  assign last_idx  = BIDX_W'(RX_MIN_LEN - 1) + BIDX_W'(len_sel);
  assign tail_last = (stop_sel == STOP_ONEHALF) ? CNT_HALF : CNT_LAST;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    shreg_n = shreg_q;
    par_n   = par_q;
    low_n   = low_q;
    perr_n  = perr_q;
    prev_n  = prev_q;
    rec_n   = rec_q;
    done_n  = 1'b0;
    if (tick_en) begin
      prev_n = rx_s;
      cnt_n  = cnt_q + CNT_W'(1);
      case (state_q)
        ST_IDLE: begin
          cnt_n = '0;
          if (prev_q && !rx_s) state_n = ST_START;
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_n = '0;
            if (rx_s) begin
              state_n = ST_IDLE;
            end else begin
              state_n = ST_DATA;
              idx_n   = '0;
              shreg_n = '0;
              par_n   = 1'b0;
              low_n   = 1'b1;
              perr_n  = 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n          = '0;
            shreg_n[idx_q] = rx_s;
            par_n          = par_q ^ rx_s;
            low_n          = low_q & ~rx_s;
            if (idx_q == last_idx) state_n = par_en ? ST_PAR : ST_STOP;
            else                   idx_n   = idx_q + BIDX_W'(1);
          end
        end
        ST_PAR: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n   = '0;
            perr_n  = par_q ^ rx_s ^ par_odd;
            low_n   = low_q & ~rx_s;
            state_n = ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n      = '0;
            done_n     = 1'b1;
            rec_n.data = shreg_q;
            rec_n.perr = par_en & perr_q;
            rec_n.ferr = ~rx_s;
            rec_n.brk  = low_q & ~rx_s;
            state_n    = (stop_sel == STOP_ONE) ? ST_IDLE : ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (cnt_q == tail_last) begin
            cnt_n   = '0;
            state_n = ST_IDLE;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      low_q   <= 1'b0;
      perr_q  <= 1'b0;
      prev_q  <= 1'b1;
      rec_q   <= '0;
    end else if (tick_en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      shreg_q <= shreg_n;
      par_q   <= par_n;
      low_q   <= low_n;
      perr_q  <= perr_n;
      prev_q  <= prev_n;
      rec_q   <= rec_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign char_done = done_q;
  assign char_rec  = rec_q;

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import uart_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 char_done,
  input  char_rec_t            char_rec,
  input  logic                 rd_strobe,
  output logic [RX_DATA_W-1:0] hold_data,
  output logic                 dr,
  output logic                 oe,
  output logic                 pe,
  output logic                 fe,
  output logic                 bi
);

  logic [RX_DATA_W-1:0] data_q, data_n;
  logic dr_q, dr_n, oe_q, oe_n, pe_q, pe_n, fe_q, fe_n, bi_q, bi_n;

  always_comb begin
    data_n = data_q;
    dr_n   = rd_strobe ? 1'b0 : dr_q;
    oe_n   = rd_strobe ? 1'b0 : oe_q;
    pe_n   = rd_strobe ? 1'b0 : pe_q;
    fe_n   = rd_strobe ? 1'b0 : fe_q;
    bi_n   = rd_strobe ? 1'b0 : bi_q;
    if (char_done) begin
      data_n = char_rec.data;
      oe_n   = oe_n | (dr_q & ~rd_strobe);
      dr_n   = 1'b1;
      pe_n   = char_rec.perr;
      fe_n   = char_rec.ferr;
      bi_n   = char_rec.brk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
    end else begin
      data_q <= data_n;
      dr_q   <= dr_n;
      oe_q   <= oe_n;
      pe_q   <= pe_n;
      fe_q   <= fe_n;
      bi_q   <= bi_n;
    end
  end

  assign hold_data = data_q;
  assign dr = dr_q;
  assign oe = oe_q;
  assign pe = pe_q;
  assign fe = fe_q;
  assign bi = bi_q;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_in,
  input  logic       tick16,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_mode,
  input  logic [1:0] stop_sel,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       err_overrun,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break
);

  logic [1:0] rst_q;
  logic       rst_n_int;
  logic       rx_s;
  logic       char_done;
  char_rec_t  char_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (rxd_in),
    .dout  (rx_s)
  );

  rx_frame_fsm #(.OS_RATE(OS_RATE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rx_s      (rx_s),
    .tick_en   (tick16),
    .len_sel   (len_sel),
    .par_sel   (par_mode),
    .stop_sel  (stop_sel),
    .char_done (char_done),
    .char_rec  (char_rec)
  );

  rx_hold_reg u_hold (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .char_done (char_done),
    .char_rec  (char_rec),
    .rd_strobe (rd_strobe),
    .hold_data (rx_data),
    .dr        (data_ready),
    .oe        (err_overrun),
    .pe        (err_parity),
    .fe        (err_frame),
    .bi        (err_break)
  );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       tick16,
  input logic [1:0] par_mode,
  input logic       char_done,
  input logic       data_ready,
  input logic       err_overrun,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_break
);

  // R10
  dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(rd_strobe));

  // R7
  brk_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_break |-> err_frame);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(data_ready));

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> data_ready);

  // R5
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> $past(tick16));

  // R2
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && (par_mode[0] == par_mode[1]) |=> !err_parity);

endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_strobe   (rd_strobe),
  .tick16      (tick16),
  .par_mode    (par_mode),
  .char_done   (char_done),
  .data_ready  (data_ready),
  .err_overrun (err_overrun),
  .err_parity  (err_parity),
  .err_frame   (err_frame),
  .err_break   (err_break)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  TICK_DIV   = 2;
  localparam int  BIT_CLKS   = 16 * TICK_DIV;
  localparam int  NVEC       = 11;

  // {len, par, stop, data, flip_par, stop_low, exp_data, exp_pe, exp_fe}
  localparam logic [25:0] VECS [NVEC] = '{
    {2'b11, 2'b00, 2'b00, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'b00, 2'b00, 2'b00, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'b01, 2'b01, 2'b00, 8'h2D, 1'b0, 1'b0, 8'h2D, 1'b0, 1'b0},
    {2'b10, 2'b10, 2'b10, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    {2'b11, 2'b01, 2'b01, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'b11, 2'b10, 2'b00, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
    {2'b10, 2'b01, 2'b00, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0},
    {2'b11, 2'b00, 2'b00, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1},
    {2'b00, 2'b10, 2'b10, 8'h13, 1'b0, 1'b0, 8'h13, 1'b0, 1'b0},
    {2'b01, 2'b11, 2'b00, 8'h3F, 1'b0, 1'b0, 8'h3F, 1'b0, 1'b0},
    {2'b11, 2'b01, 2'b00, 8'hC3, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd_in;
  logic       tick16 = 1'b0;
  logic       tick_on = 1'b0;
  logic       tick_ph = 1'b0;
  logic [1:0] len_sel, par_mode, stop_sel;
  logic       rd_strobe;
  logic [7:0] rx_data;
  logic       data_ready, err_overrun, err_parity, err_frame, err_break;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  uart_rx_core u_uart_rx_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd_in      (rxd_in),
    .tick16      (tick16),
    .len_sel     (len_sel),
    .par_mode    (par_mode),
    .stop_sel    (stop_sel),
    .rd_strobe   (rd_strobe),
    .rx_data     (rx_data),
    .data_ready  (data_ready),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_ph = ~tick_ph;
    tick16  = tick_on & tick_ph;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic v, input int nbits);
    rxd_in = v;
    wait_clks(nbits * BIT_CLKS);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic send_char(input logic [1:0] len, input logic [1:0] par,
                           input logic [1:0] stp, input logic [7:0] d,
                           input logic flip, input logic slow);
    int   nb;
    logic p;
    nb = 5 + int'(len);
    drive(1'b0, 1);
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      drive(d[i], 1);
      p = p ^ d[i];
    end
    if (par == 2'b01 || par == 2'b10) drive(p ^ (par == 2'b10) ^ flip, 1);
    drive(~slow, 1);
    rxd_in = 1'b1;
    if (stp == 2'b01) wait_clks(BIT_CLKS / 2);
    else if (stp != 2'b00) wait_clks(BIT_CLKS);
  endtask

  task automatic set_fmt(input logic [1:0] l, input logic [1:0] p, input logic [1:0] s);
    @(negedge clk);
    len_sel = l; par_mode = p; stop_sel = s;
  endtask

  initial begin
    rst_n = 1'b0; rxd_in = 1'b1; rd_strobe = 1'b0;
    len_sel = 2'b11; par_mode = 2'b00; stop_sel = 2'b00;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(4);
    // R11 reset state
    chk("R11 data_ready", data_ready, 0);
    chk("R11 overrun", err_overrun, 0);
    chk("R11 parity", err_parity, 0);
    chk("R11 frame", err_frame, 0);
    chk("R11 break", err_break, 0);
    chk("R11 rx_data", rx_data, 0);
    tick_on = 1'b1;
    drive(1'b1, 2);

    // R1 R2 R3 R6 R9 R10: table of formats and expected results
    for (int v = 0; v < NVEC; v++) begin
      set_fmt(VECS[v][25:24], VECS[v][23:22], VECS[v][21:20]);
      drive(1'b1, 1);
      send_char(VECS[v][25:24], VECS[v][23:22], VECS[v][21:20],
                VECS[v][19:12], VECS[v][11], VECS[v][10]);
      drive(1'b1, 1);
      chk("R9 data_ready", data_ready, 1);
      chk("R1 rx_data", rx_data, VECS[v][9:2]);
      chk("R2 parity", err_parity, VECS[v][1]);
      chk("R6 frame", err_frame, VECS[v][0]);
      chk("R7 no break", err_break, 0);
      do_read();
      chk("R10 dr cleared", data_ready, 0);
      chk("R10 flags cleared", {err_parity, err_frame, err_overrun}, 0);
    end

    // R4 false start: short glitch, then a valid character
    set_fmt(2'b11, 2'b00, 2'b00);
    rxd_in = 1'b0; wait_clks(3 * TICK_DIV);
    drive(1'b1, 3);
    chk("R4 glitch ignored", data_ready, 0);
    send_char(2'b11, 2'b00, 2'b00, 8'h96, 1'b0, 1'b0);
    drive(1'b1, 1);
    chk("R4 recovery dr", data_ready, 1);
    chk("R4 recovery data", rx_data, 8'h96);
    do_read();

    // R5 no ticks, no reception
    tick_on = 1'b0;
    send_char(2'b11, 2'b00, 2'b00, 8'h3C, 1'b0, 1'b0);
    drive(1'b1, 2);
    chk("R5 no tick no char", data_ready, 0);
    tick_on = 1'b1;
    drive(1'b1, 2);
    chk("R5 still idle", data_ready, 0);

    // R7 break held low
    drive(1'b0, 11);
    chk("R7 break dr", data_ready, 1);
    chk("R7 break flag", err_break, 1);
    chk("R7 break frame", err_frame, 1);
    chk("R7 break data", rx_data, 0);
    do_read();
    drive(1'b0, 3);
    chk("R7 no restart while low", data_ready, 0);
    drive(1'b1, 2);
    send_char(2'b11, 2'b00, 2'b00, 8'h42, 1'b0, 1'b0);
    drive(1'b1, 1);
    chk("R7 after break data", rx_data, 8'h42);
    chk("R7 after break flag", err_break, 0);
    do_read();

    // R8 overrun
    send_char(2'b11, 2'b00, 2'b00, 8'h11, 1'b0, 1'b0);
    drive(1'b1, 1);
    send_char(2'b11, 2'b00, 2'b00, 8'h22, 1'b0, 1'b0);
    drive(1'b1, 1);
    chk("R8 overrun flag", err_overrun, 1);
    chk("R8 newest kept", rx_data, 8'h22);
    do_read();
    chk("R10 overrun cleared", err_overrun, 0);

    // R3 stop length: 5N, early low after one stop bit
    set_fmt(2'b00, 2'b00, 2'b10);
    drive(1'b0, 1); drive(1'b1, 5); drive(1'b1, 1);
    drive(1'b0, 4); drive(1'b1, 4);
    chk("R3 two-stop dr", data_ready, 1);
    chk("R3 two-stop data", rx_data, 8'h1F);
    chk("R3 two-stop edge ignored", err_overrun, 0);
    do_read();
    set_fmt(2'b00, 2'b00, 2'b00);
    drive(1'b0, 1); drive(1'b1, 5); drive(1'b1, 1);
    drive(1'b0, 4); drive(1'b1, 4);
    chk("R3 one-stop second char", rx_data, 8'h18);
    chk("R3 one-stop overrun", err_overrun, 1);
    do_read();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clks(150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule